// File: doc/BRIEF.md
# Local Interrupt Combiner

This block merges two local interrupt pins and one software-raised request into a single registered, active-low interrupt request suitable for a PCI-style shared interrupt line. Each local pin is first synchronized to the block clock. It is then handled either as a level source with a selectable active polarity, or as a rising-edge source that sets a sticky latch. A global enable gates everything that reaches the output.

Software sees the block through a small synchronous register port with two 32-bit words. Address 0 is the control/status word. It holds the per-pin enables, polarities, mode selects, read-only status flags and write-one edge-clear strobes, plus the global enable and the software request. Address 1 holds a writable interrupt-line byte and a read-only interrupt-pin byte. Both are plain storage and have no effect on the interrupt logic. Reads are combinational from the registers. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `lirq_combiner`

## Requirements
- R1: After reset, the control word reads 0 (both pins enabled off, level mode, active-low polarity, global enable and software request clear), `irq_n` is 1, and address 1 reads 0x0000_0100 (pin byte 1 in bits 15:8, line byte 0 in bits 7:0).
- R2: In level mode the control bit at position 1 (pin 0) or 4 (pin 1) selects the polarity, where 1 means active-high and 0 means active-low. Status bit 2 (pin 0) or 5 (pin 1) reads 1 exactly when that pin is enabled (bit 0 or 3) and its synchronized value equals the active level. Writes to status bits are ignored.
- R3: `irq_n` is registered. It goes low on the clock edge after global enable (bit 6) is 1 while any status bit or the software bit is 1. It goes high on the edge after that condition stops holding.
- R4: A level source stops driving the output when the pin goes inactive, when its enable is cleared, or when global enable is cleared. If the pin is still active when the enables are set again, the request returns at once.
- R5: With mode bit 8 (pin 0) or 9 (pin 1) set, a low-to-high transition of the synchronized pin sets a latch while the pin and global enables are set. The latch drives the status bit and holds whatever the pin does afterwards. Polarity has no effect in this mode.
- R6: Writing 1 to bit 10 (pin 0) or 11 (pin 1) at address 0 clears that pin's edge latch. If a fresh rising edge is detected in the same cycle, the latch stays set. These bits always read 0.
- R7: Clearing a pin's enable, clearing global enable, or leaving edge mode clears the edge latch. After re-enabling, a pin that stays high raises no request until a new low-to-high transition occurs.
- R8: Software request bit 7 drives the output low when bit 6 is also 1. The output returns high when either bit is cleared.
- R9: Bits 7:0 at address 1 are read/write. Bits 15:8 at address 1 always read 1, and writes to them are ignored. Neither byte changes `irq_n`.
- R10: Each pin passes through two synchronizer flops. In level mode a pin change shows in status two edges later and on `irq_n` three edges later. In edge mode it shows in status three edges later and on `irq_n` four edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lint_i | input | 2 | Asynchronous local interrupt pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Word select: 0 control/status, 1 pin/line |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected word |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
The hardest case to reach is an edge latch that was cleared by disabling while its pin is still high. Once enables return, the latch must stay quiet, and it must fire only on the next genuine low-to-high transition. The directed part of the bench holds the pin high across a disable/re-enable pair and then pulses it. It does this for the pin enable and for the global enable separately. A long random phase then mixes pin toggles with random control writes, so edge-clear strobes land in the same cycle as detected edges. A cycle-level reference model is compared with `rdata` and `irq_n` after every clock.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int CTL_W  = 32;
  localparam int NSRC   = 2;
  localparam int GEN_POS = 6;
  localparam int SW_POS  = 7;
  localparam int LINE_W  = 8;

  // Control word layout: per-source fields computed from the source index.
  function automatic int en_pos(input int i);
    return 3 * i;
  endfunction

  function automatic int pol_pos(input int i);
    return 3 * i + 1;
  endfunction

  function automatic int stat_pos(input int i);
    return 3 * i + 2;
  endfunction

  function automatic int mode_pos(input int i);
    return 8 + i;
  endfunction

  function automatic int clr_pos(input int i);
    return 10 + i;
  endfunction

  // Level match: pol=1 active-high, pol=0 active-low.
  function automatic logic level_hit(input logic s, input logic pol);
    return pol ? s : ~s;
  endfunction

  typedef struct packed {
    logic en;
    logic pol;
    logic edge_mode;
  } src_cfg_t;
endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[k] <= 1'b0;
          else        chain[k] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[k] <= 1'b0;
          else        chain[k] <= chain[k-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lirq_source.sv
module lirq_source
  import lirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_s,
  input  src_cfg_t cfg,
  input  logic     gen,
  input  logic     clr_pulse,
  output logic     rise,
  output logic     active
);
  logic prev_q;
  logic latch_q;
  logic latch_d;
  logic armed;

  assign rise  = pin_s & ~prev_q;
  assign armed = cfg.en & gen & cfg.edge_mode;

  always_comb begin
    if (armed) latch_d = (latch_q & ~clr_pulse) | rise;
    else       latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= pin_s;
      latch_q <= latch_d;
    end
  end

  assign active = cfg.edge_mode ? latch_q : (cfg.en & level_hit(pin_s, cfg.pol));

  p_latch_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && latch_q && !clr_pulse) |=> latch_q);
  p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rise) |=> latch_q);
  p_clear_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !rise) |=> !latch_q);
  p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.en || !gen) |=> !latch_q);
endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
#(
  parameter logic [LINE_W-1:0] PIN_VALUE = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [CTL_W-1:0] wdata,
  input  logic [NSRC-1:0]  status,
  output logic [CTL_W-1:0] rdata,
  output logic [NSRC-1:0]  en_q,
  output logic [NSRC-1:0]  pol_q,
  output logic [NSRC-1:0]  mode_q,
  output logic [NSRC-1:0]  clr_pulse,
  output logic             gen_q,
  output logic             sw_q
);
  logic [LINE_W-1:0] line_q;
  logic              ctl_wr;
  logic              aux_wr;

  assign ctl_wr = wr_en & ~addr;
  assign aux_wr = wr_en & addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '0;
      gen_q  <= 1'b0;
      sw_q   <= 1'b0;
      line_q <= '0;
    end else begin
      if (ctl_wr) begin
        for (int i = 0; i < NSRC; i++) begin
          en_q[i]   <= wdata[en_pos(i)];
          pol_q[i]  <= wdata[pol_pos(i)];
          mode_q[i] <= wdata[mode_pos(i)];
        end
        gen_q <= wdata[GEN_POS];
        sw_q  <= wdata[SW_POS];
      end
      if (aux_wr) line_q <= wdata[LINE_W-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) clr_pulse[i] = ctl_wr & wdata[clr_pos(i)];
  end

  always_comb begin
    rdata = '0;
    if (!addr) begin
      for (int i = 0; i < NSRC; i++) begin
        rdata[en_pos(i)]   = en_q[i];
        rdata[pol_pos(i)]  = pol_q[i];
        rdata[stat_pos(i)] = status[i];
        rdata[mode_pos(i)] = mode_q[i];
      end
      rdata[GEN_POS] = gen_q;
      rdata[SW_POS]  = sw_q;
    end else begin
      rdata[2*LINE_W-1:0] = {PIN_VALUE, line_q};
    end
  end

  p_line_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    aux_wr |=> (line_q == $past(wdata[LINE_W-1:0])));
  p_aux_keeps_ctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    aux_wr |=> ($stable(gen_q) && $stable(sw_q) && $stable(en_q)));
endmodule

// File: rtl/lirq_combiner.sv
module lirq_combiner
  import lirq_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [LINE_W-1:0] PIN_VALUE   = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  lint_i,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] rdata,
  output logic             irq_n
);
  logic [NSRC-1:0] pin_s;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] status;
  logic [NSRC-1:0] en_q, pol_q, mode_q, clr_pulse;
  logic            gen_q, sw_q;
  logic            irq_req;

  lirq_regs #(.PIN_VALUE(PIN_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .status(status), .rdata(rdata), .en_q(en_q), .pol_q(pol_q),
    .mode_q(mode_q), .clr_pulse(clr_pulse), .gen_q(gen_q), .sw_q(sw_q)
  );

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      src_cfg_t cfg;
      assign cfg = '{en: en_q[i], pol: pol_q[i], edge_mode: mode_q[i]};

      lirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(lint_i[i]), .q(pin_s[i])
      );

      lirq_source u_src (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s[i]), .cfg(cfg), .gen(gen_q),
        .clr_pulse(clr_pulse[i]), .rise(rise[i]), .active(status[i])
      );
    end
  endgenerate

  assign irq_req = gen_q & ((|status) | sw_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~irq_req;
  end

  p_gen_gates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |=> irq_n);
  p_req_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && (|status)) |=> !irq_n);
  p_sw_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && sw_q) |=> !irq_n);
  p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|status) && !sw_q) |=> irq_n);
endmodule

// File: tb/lirq_combiner_tb.sv
module lirq_combiner_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lint = 2'b00;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #4 clk = ~clk;

  lirq_combiner u_dut (
    .clk(clk), .rst_n(rst_n), .lint_i(lint), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  // Reference model state
  bit       m_en[2], m_pol[2], m_mode[2], m_lat[2];
  bit       m_gen, m_sw, m_irqn;
  bit [7:0] m_line;
  bit [1:0] hist[$];   // [0]=edge-detect previous, [1]=synchronized, [2]=first stage

  function automatic bit m_stat(int i);
    if (m_mode[i]) return m_lat[i];
    return m_en[i] && (hist[1][i] == m_pol[i]);
  endfunction

  function automatic bit [31:0] m_rdata(bit a);
    bit [31:0] r = '0;
    if (a) return {16'h0, 8'h01, m_line};
    for (int i = 0; i < 2; i++) begin
      r[3*i]     = m_en[i];
      r[3*i + 1] = m_pol[i];
      r[3*i + 2] = m_stat(i);
      r[8 + i]   = m_mode[i];
    end
    r[6] = m_gen;
    r[7] = m_sw;
    return r;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 2; i++) begin
      m_en[i] = 0; m_pol[i] = 0; m_mode[i] = 0; m_lat[i] = 0;
    end
    m_gen = 0; m_sw = 0; m_irqn = 1; m_line = 0;
    hist.delete();
    for (int k = 0; k < 3; k++) hist.push_back(2'b00);
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      bit st_any;
      bit nl[2];
      st_any = m_stat(0) || m_stat(1);
      for (int i = 0; i < 2; i++) begin
        bit rs, cl;
        rs = hist[1][i] && !hist[0][i];
        cl = wr_en && !addr && wdata[10 + i];
        nl[i] = (m_en[i] && m_gen && m_mode[i]) ? ((m_lat[i] && !cl) || rs) : 1'b0;
      end
      m_irqn = !(m_gen && (st_any || m_sw));
      m_lat[0] = nl[0];
      m_lat[1] = nl[1];
      if (wr_en && !addr) begin
        for (int i = 0; i < 2; i++) begin
          m_en[i]   = wdata[3*i];
          m_pol[i]  = wdata[3*i + 1];
          m_mode[i] = wdata[8 + i];
        end
        m_gen = wdata[6];
        m_sw  = wdata[7];
      end
      if (wr_en && addr) m_line = wdata[7:0];
      hist.push_back(lint);
      void'(hist.pop_front());
    end
  end

  // Compare every cycle, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      bit [31:0] er;
      er = m_rdata(addr);
      checks++;
      if (irq_n !== m_irqn) begin
        errors++;
        $display("FAIL %s irq_n actual=%b expected=%b at %0t", cur_req, irq_n, m_irqn, $time);
      end
      checks++;
      if (rdata !== er) begin
        errors++;
        $display("FAIL %s rdata actual=%h expected=%h at %0t", cur_req, rdata, er, $time);
      end
    end
  end

  task automatic wr(input bit a, input bit [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input bit [1:0] v);
    @(negedge clk);
    lint = v;
  endtask

  // Directed check of irq_n level at the next sample point, named by requirement
  task automatic expect_irq(input bit v, input string tag);
    @(posedge clk); #3;
    checks++;
    if (irq_n !== v) begin
      errors++;
      $display("FAIL %s directed irq_n actual=%b expected=%b", tag, irq_n, v);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    cur_req = "R1";
    @(negedge clk); rst_n = 1;
    idle(2);
    expect_irq(1'b1, "R1");
    addr = 1; idle(2); addr = 0; idle(2);

    // Level mode, pin 0 active-high; pin 1 active-low
    cur_req = "R2";
    wr(0, 32'h0000_0043);
    pins(2'b01); idle(4);
    expect_irq(1'b0, "R2");
    cur_req = "R10";
    pins(2'b00); idle(1);
    expect_irq(1'b0, "R10");
    idle(3);
    expect_irq(1'b1, "R10");
    cur_req = "R2";
    wr(0, 32'h0000_0048 | 32'h24);    // status bits written: ignored
    idle(4);
    expect_irq(1'b0, "R2");

    // Level clearing and immediate return
    cur_req = "R4";
    wr(0, 32'h0000_0040); idle(2);
    expect_irq(1'b1, "R4");
    wr(0, 32'h0000_0048); idle(1);
    expect_irq(1'b0, "R4");
    wr(0, 32'h0000_0008); idle(2);
    expect_irq(1'b1, "R4");
    wr(0, 32'h0000_0048); idle(2);
    pins(2'b10); idle(4);
    expect_irq(1'b1, "R4");

    // Edge mode on pin 0
    cur_req = "R5";
    pins(2'b00);
    wr(0, 32'h0000_0141); idle(3);
    pins(2'b01); idle(5);
    expect_irq(1'b0, "R5");
    pins(2'b00); idle(6);
    expect_irq(1'b0, "R5");
    cur_req = "R6";
    wr(0, 32'h0000_0541); idle(2);
    expect_irq(1'b1, "R6");

    // Disable with pin held high, then re-enable
    cur_req = "R7";
    pins(2'b01); idle(6);
    wr(0, 32'h0000_0140); idle(2);
    wr(0, 32'h0000_0141); idle(8);
    expect_irq(1'b1, "R7");
    pins(2'b00); idle(3);
    pins(2'b01); idle(5);
    expect_irq(1'b0, "R7");
    wr(0, 32'h0000_0101); idle(2);
    wr(0, 32'h0000_0141); idle(8);
    expect_irq(1'b1, "R7");
    pins(2'b00); idle(6);

    // Software request
    cur_req = "R8";
    wr(0, 32'h0000_0080); idle(2);
    expect_irq(1'b1, "R8");
    wr(0, 32'h0000_00C0); idle(1);
    expect_irq(1'b0, "R8");
    wr(0, 32'h0000_0040); idle(2);
    expect_irq(1'b1, "R8");

    // Pin/line word
    cur_req = "R9";
    wr(1, 32'h1234_AB5C);
    addr = 1; idle(3);
    expect_irq(1'b1, "R9");
    addr = 0; idle(2);

    // Random mix
    cur_req = "R6";
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      lint = 2'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        wr_en = 1;
        addr  = ($urandom_range(0, 9) == 0);
        wdata = $urandom | 32'h40;
      end else begin
        wr_en = 0;
        addr  = ($urandom_range(0, 5) == 0);
      end
    end
    @(negedge clk); wr_en = 0; addr = 0;
    idle(4);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule